// File: doc/BRIEF.md
# Multi-Master Doorbell Bank

This block is a bank of doorbells through which processors on a chip signal one another. Each doorbell belongs to one master, the master whose ID equals the doorbell's index. That owner decides which other masters may ring it by setting bits in the doorbell's enable mask. When a permitted master rings, the bit position equal to its own ID is latched into the doorbell's raw and pending vectors. The doorbell's level interrupt then stays high until the owner acknowledges the bit.

Masters reach the bank through several independent register ports. Every request on a port carries a master ID sideband. All ports act in the same cycle. Rings, acknowledges and enable updates from different ports merge into one update of each doorbell. Reads return one cycle after the request.

A read-only dimensioning word at address 0 reports how many units of each kind the surrounding hub holds. The doorbell region begins at a base address derived from those counts. Doorbell `i` sits at base + `i`*0x100.

Top module: `doorbell_bank`

## Requirements
- R1: After reset every enable, raw and pending vector is zero and every `irq` bit is low.
- R2: A read of address 0 returns the dimensioning word: bits 3:0 mailbox count, 7:4 shared semaphore count, 11:8 arbitrated semaphore count, 15:12 doorbell count, 19:16 shared interrupt count, all other bits zero.
- R3: Doorbell `i` occupies base + `i`*0x100, where base = (1 + mailboxes/2 + shared semaphores + arbitrated semaphores) << 16. Within a doorbell, byte offset 0x0 is the trigger register, 0x4 enable, 0x8 raw and 0xC pending. A read raises `rsp_valid` on the same port exactly one cycle later, with the data in `rsp_data`.
- R4: A write to a trigger register with bit 0 of the data set, from master `m`, sets bit `m` of that doorbell's raw and pending vectors, provided enable bit `m` is set.
- R5: A ring from a master whose enable bit is clear, or a trigger write with bit 0 clear, changes neither raw nor pending.
- R6: Writing ones to the pending register clears exactly those bits and leaves the others. Writing ones to the raw register does the same to raw, independently of pending.
- R7: `irq[i]` is high exactly while doorbell `i` has a pending bit whose enable bit is also set. Clearing the enable bit drops the interrupt without clearing pending.
- R8: When a ring and an acknowledge of the same bit arrive on different ports in the same cycle, the bit ends up set.
- R9: Writes to a doorbell's enable, raw or pending register take effect only when the writing master's ID equals the doorbell index; other writes to them are ignored. Bits of enable at or above `NUM_MASTERS` always read zero.
- R10: When several ports write the same enable register in one cycle, the highest-numbered port's value is kept.
- R11: Reads of a trigger register, of any unmapped offset, or of a doorbell index at or beyond `NUM_DB` return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Request strobe per port |
| req_write | input | NPORT | 1 = write, 0 = read, per port |
| req_addr | input | NPORT x AW | Byte address per port |
| req_wdata | input | NPORT x 32 | Write data per port |
| req_master | input | NPORT x 5 | Master ID of the requester per port |
| rsp_valid | output | NPORT | Read data valid, one cycle after a read |
| rsp_data | output | NPORT x 32 | Read data per port |
| irq | output | NUM_DB | Level interrupt per doorbell |

## Verification
Rings are sent from masters inside and outside a doorbell's enable mask, and with trigger data whose bit 0 is clear. This separates the accept path from the drop path. Acknowledges are written by the owner and by strangers, and with partial masks. Together they show that clears are selective, owner-gated, and separate between raw and pending. Two-port collisions (a ring against a clear of the same bit, and two enable writes to one doorbell) expose the merge priority. A second doorbell with its own owner shows that interrupts and address decoding stay per doorbell, and reads of out-of-range and unmapped addresses probe the decoder edges.

// File: rtl/doorbell_bank.sv
module doorbell_bank #(
  parameter int NPORT       = 2,
  parameter int AW          = 20,
  parameter int NUM_DB      = 8,
  parameter int NUM_MASTERS = 8,
  parameter int NSM         = 4,
  parameter int NSS         = 2,
  parameter int NAS         = 2,
  parameter int NSI         = 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NPORT-1:0]             req_valid,
  input  logic [NPORT-1:0]             req_write,
  input  logic [NPORT-1:0][AW-1:0]     req_addr,
  input  logic [NPORT-1:0][31:0]       req_wdata,
  input  logic [NPORT-1:0][4:0]        req_master,
  output logic [NPORT-1:0]             rsp_valid,
  output logic [NPORT-1:0][31:0]       rsp_data,
  output logic [NUM_DB-1:0]            irq
);
  localparam int          DB_BASE = (1 + NSM / 2 + NSS + NAS) << 16;
  localparam int          IW      = (NUM_DB > 1) ? $clog2(NUM_DB) : 1;
  localparam logic [31:0] MMASK   = 32'((64'd1 << NUM_MASTERS) - 64'd1);
  localparam logic [31:0] DIM     = {12'd0, 4'(NSI), 4'(NUM_DB), 4'(NAS), 4'(NSS), 4'(NSM)};

  logic [NUM_DB-1:0][31:0] en_q, raw_q, pend_q;
  logic [NUM_DB-1:0][31:0] ring_set, pend_clr, raw_clr, en_wd;
  logic [NUM_DB-1:0]       en_we;

  logic [NPORT-1:0][AW-1:0] off;
  logic [NPORT-1:0]         hit, own;
  logic [NPORT-1:0][IW-1:0] idx;
  logic [NPORT-1:0][1:0]    sel;
  logic [NPORT-1:0][31:0]   rd_val;

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      off[p] = req_addr[p] - AW'(DB_BASE);
      hit[p] = (req_addr[p] >= AW'(DB_BASE)) &&
               (32'(off[p][AW-1:8]) < 32'(NUM_DB)) &&
               (off[p][7:4] == 4'd0) && (off[p][1:0] == 2'd0);
      idx[p] = off[p][8 +: IW];
      sel[p] = off[p][3:2];
      own[p] = (32'(req_master[p]) == 32'(idx[p]));
    end
  end

  always_comb begin
    for (int d = 0; d < NUM_DB; d++) begin
      ring_set[d] = '0;
      pend_clr[d] = '0;
      raw_clr[d]  = '0;
      en_wd[d]    = '0;
      en_we[d]    = 1'b0;
    end
    for (int p = 0; p < NPORT; p++) begin
      if (req_valid[p] && req_write[p] && hit[p]) begin
        case (sel[p])
          2'd0: if (req_wdata[p][0] && ({1'b0, req_master[p]} < 6'(NUM_MASTERS)) &&
                    en_q[idx[p]][req_master[p]])
                  ring_set[idx[p]][req_master[p]] = 1'b1;
          2'd1: if (own[p]) begin
                  en_we[idx[p]] = 1'b1;
                  en_wd[idx[p]] = req_wdata[p] & MMASK;
                end
          2'd2: if (own[p]) raw_clr[idx[p]]  = raw_clr[idx[p]]  | req_wdata[p];
          default: if (own[p]) pend_clr[idx[p]] = pend_clr[idx[p]] | req_wdata[p];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      raw_q  <= '0;
      pend_q <= '0;
    end else begin
      for (int d = 0; d < NUM_DB; d++) begin
        if (en_we[d]) en_q[d] <= en_wd[d];
        raw_q[d]  <= (raw_q[d]  & ~raw_clr[d])  | ring_set[d];
        pend_q[d] <= (pend_q[d] & ~pend_clr[d]) | ring_set[d];
      end
    end
  end

  generate
    for (genvar d = 0; d < NUM_DB; d++) begin : g_irq
      assign irq[d] = |(pend_q[d] & en_q[d]);
    end
  endgenerate

  always_comb begin
    for (int p = 0; p < NPORT; p++) begin
      rd_val[p] = '0;
      if (req_addr[p] == '0) rd_val[p] = DIM;
      else if (hit[p]) begin
        case (sel[p])
          2'd1:    rd_val[p] = en_q[idx[p]];
          2'd2:    rd_val[p] = raw_q[idx[p]];
          2'd3:    rd_val[p] = pend_q[idx[p]];
          default: rd_val[p] = '0;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_data  <= '0;
    end else begin
      for (int p = 0; p < NPORT; p++) begin
        rsp_valid[p] <= req_valid[p] && !req_write[p];
        rsp_data[p]  <= (req_valid[p] && !req_write[p]) ? rd_val[p] : '0;
      end
    end
  end
endmodule

// File: rtl/doorbell_bank_chk.sv
module doorbell_bank_chk #(
  parameter int NPORT  = 2,
  parameter int NUM_DB = 8
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NPORT-1:0]        req_valid,
  input logic [NPORT-1:0]        req_write,
  input logic [NPORT-1:0]        rsp_valid,
  input logic [NUM_DB-1:0]       irq,
  input logic [NUM_DB-1:0][31:0] en,
  input logic [NUM_DB-1:0][31:0] pend
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (irq == '0));

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      p_rsp_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid[p] |-> $past(req_valid[p] && !req_write[p]));
    end
    for (genvar d = 0; d < NUM_DB; d++) begin : g_db
      p_set_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (((pend[d] & ~$past(pend[d])) & ~$past(en[d])) == 32'd0));
      p_irq_drop_has_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq[d]) |-> (!$stable(pend[d]) || !$stable(en[d])));
    end
  endgenerate
endmodule

bind doorbell_bank doorbell_bank_chk #(.NPORT(NPORT), .NUM_DB(NUM_DB)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .irq(irq), .en(en_q), .pend(pend_q)
);

// File: tb/doorbell_bank_bench.sv
`timescale 1ns/1ps
module doorbell_bank_bench;
  localparam int NPORT = 2;
  localparam int AW    = 20;
  localparam int NDB   = 8;
  localparam logic [19:0] BASE = 20'h70000;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [NPORT-1:0]         req_valid = '0;
  logic [NPORT-1:0]         req_write = '0;
  logic [NPORT-1:0][AW-1:0] req_addr = '0;
  logic [NPORT-1:0][31:0]   req_wdata = '0;
  logic [NPORT-1:0][4:0]    req_master = '0;
  logic [NPORT-1:0]         rsp_valid;
  logic [NPORT-1:0][31:0]   rsp_data;
  logic [NDB-1:0]           irq;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  doorbell_bank u_doorbell_bank (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_master(req_master),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
  );

  always #2.5 clk = ~clk;

  function automatic logic [19:0] db(int i, int o);
    return BASE + 20'(i * 256) + 20'(o);
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int p, int m, logic [19:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid[p] = 1'b1; req_write[p] = 1'b1;
    req_addr[p] = a; req_wdata[p] = d; req_master[p] = 5'(m);
    @(negedge clk);
    req_valid[p] = 1'b0; req_write[p] = 1'b0;
  endtask

  task automatic wr2(int m0, logic [19:0] a0, logic [31:0] d0,
                     int m1, logic [19:0] a1, logic [31:0] d1);
    @(negedge clk);
    req_valid = 2'b11; req_write = 2'b11;
    req_addr[0] = a0; req_wdata[0] = d0; req_master[0] = 5'(m0);
    req_addr[1] = a1; req_wdata[1] = d1; req_master[1] = 5'(m1);
    @(negedge clk);
    req_valid = '0; req_write = '0;
  endtask

  task automatic rd(logic [19:0] a, logic [31:0] e, string tag);
    @(negedge clk);
    req_valid[0] = 1'b1; req_write[0] = 1'b0; req_addr[0] = a; req_master[0] = 5'd0;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    req_valid[0] = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_valid[0]) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R3 unexpected response actual=%h expected=none", rsp_data[0]);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_data[0], e, t);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(32'(irq), 32'h0, "R1 irq after reset");
    rd(db(1, 4), 32'h0, "R1 enable db1 after reset");
    rd(db(3, 12), 32'h0, "R1 pending db3 after reset");
    rd(20'h0, 32'h00018224, "R2 dimensioning word");

    wr(0, 1, db(1, 4), 32'hFFFF_0028);
    rd(db(1, 4), 32'h28, "R9 owner enable write masked to masters");
    wr(0, 3, db(1, 4), 32'hFF);
    rd(db(1, 4), 32'h28, "R9 non-owner enable write ignored");

    wr(1, 3, db(1, 0), 32'h1);
    chk(32'(irq), 32'h02, "R4 irq after accepted ring");
    rd(db(1, 12), 32'h08, "R4 pending bit of ringing master");
    rd(db(1, 8), 32'h08, "R4 raw bit of ringing master");

    wr(0, 2, db(1, 0), 32'h1);
    wr(1, 5, db(1, 0), 32'h0);
    rd(db(1, 12), 32'h08, "R5 disabled ring and zero-data ring dropped");
    rd(db(1, 8), 32'h08, "R5 raw unchanged by dropped rings");

    wr(1, 5, db(1, 0), 32'h1);
    rd(db(1, 12), 32'h28, "R4 second master pending");
    wr(0, 5, db(1, 12), 32'h08);
    rd(db(1, 12), 32'h28, "R9 non-owner acknowledge ignored");

    wr(0, 1, db(1, 12), 32'h08);
    rd(db(1, 12), 32'h20, "R6 selective acknowledge");
    chk(32'(irq), 32'h02, "R6 irq stays with remaining bit");
    rd(db(1, 8), 32'h28, "R6 raw independent of pending clear");
    wr(0, 1, db(1, 8), 32'h28);
    rd(db(1, 8), 32'h0, "R6 raw write-one-to-clear");

    wr2(1, db(1, 12), 32'h20, 5, db(1, 0), 32'h1);
    rd(db(1, 12), 32'h20, "R8 ring wins over same-cycle clear");
    wr(0, 1, db(1, 12), 32'h20);
    chk(32'(irq), 32'h0, "R7 irq low when nothing pending");

    wr(1, 3, db(1, 0), 32'h1);
    chk(32'(irq), 32'h02, "R7 irq high after ring");
    wr(0, 1, db(1, 4), 32'h0);
    chk(32'(irq), 32'h0, "R7 irq low when enable cleared");
    rd(db(1, 12), 32'h08, "R7 pending kept while disabled");
    wr(0, 1, db(1, 4), 32'h08);
    chk(32'(irq), 32'h02, "R7 irq returns on re-enable");
    wr(0, 1, db(1, 12), 32'hFFFF_FFFF);

    wr2(1, db(1, 4), 32'h01, 1, db(1, 4), 32'h02);
    rd(db(1, 4), 32'h02, "R10 highest port enable write kept");

    rd(db(1, 0), 32'h0, "R11 trigger reads zero");
    rd(db(NDB, 4), 32'h0, "R11 doorbell index beyond range reads zero");
    rd(db(1, 16), 32'h0, "R11 unmapped offset reads zero");

    wr(0, 3, db(3, 4), 32'h02);
    wr(1, 1, db(3, 0), 32'h1);
    chk(32'(irq), 32'h08, "R3 ring reaches only doorbell 3");
    rd(db(3, 8), 32'h02, "R3 raw of doorbell 3");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3 missing responses actual=%0d expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule